// File: doc/BRIEF.md
# Double-Buffered Pixel Output Path

This block connects two frame memories to the colour outputs of a raster display. Each memory holds one 6-bit pixel per location, 2 bits each for red, green and blue. Both memories are addressed with the same {Y,X} address that the display timing memory uses. At any moment one memory is the front buffer, read at the display counter address. The other is the back buffer, which the CPU or a copy engine reads and writes while it builds the next image. The CPU address is made of a latched upper part and a lower part taken straight from the CPU bus.

The CPU asks for the roles to exchange by pulsing a swap request. The request is held in a flip-flop, and the exchange happens only on the clock where the timing memory raises both the X-reset and the Y-reset strobe, which marks the end of a frame. This means a frame is never shown half from one buffer and half from the other. The pixel read from the front buffer is captured in an output register for one clock. A synchronous clear driven by blank forces that register to black. The buffer roles reset to a fixed state in which only the back buffer can be written, so the two memories never contend for the bus.

Top module: `pixbuf_path`

## Requirements
- R1: While rst_n is low, pix_out is 0, front_id is 0 (buffer 0 shows the picture), swap_pending is 0 and cpu_rdata is 0. With cpu_wr low, both buf_we bits are 0.
- R2: The front buffer (index front_id) gets buf_addr = disp_addr and buf_we = 0. The back buffer gets buf_addr = {upper latch, cpu_lo_addr} with the latch in the upper HI_W bits, buf_we = cpu_wr and buf_wdata = cpu_wdata. These paths are combinational. No more than one buf_we bit is ever high.
- R3: A clock with cpu_hi_load high loads cpu_hi_data into the upper latch. While cpu_hi_load is low, the latch keeps its value whatever cpu_hi_data does.
- R4: After each clock with blank low, pix_out equals the buf_rdata of the buffer that was front at that clock, as it stood at that clock.
- R5: After each clock with blank high, pix_out is 0.
- R6: A clock with swap_req high sets swap_pending from the next clock on. front_id does not change until a frame boundary.
- R7: A frame boundary is a clock with x_reset and y_reset both high. At a boundary with swap_pending high, front_id toggles and swap_pending clears after that clock. x_reset alone or y_reset alone changes neither.
- R8: Further requests while a swap is pending, including one in the boundary clock itself, merge into the single pending swap. A request in a boundary clock with nothing pending sets swap_pending but does not swap.
- R9: A clock with cpu_rd high captures the back buffer's buf_rdata into cpu_rdata. Otherwise cpu_rdata holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_addr | input | X_W+Y_W | Display counter address {Y,X} |
| x_reset | input | 1 | X-counter reset strobe from the timing memory |
| y_reset | input | 1 | Y-counter reset strobe from the timing memory |
| blank | input | 1 | Blank strobe; clears the output pixel register |
| swap_req | input | 1 | Request to exchange the buffer roles |
| cpu_hi_load | input | 1 | Loads the upper address latch |
| cpu_hi_data | input | HI_W | Value for the upper address latch |
| cpu_lo_addr | input | X_W+Y_W-HI_W | Lower CPU address bits, taken directly |
| cpu_wr | input | 1 | CPU write to the back buffer |
| cpu_rd | input | 1 | CPU read from the back buffer |
| cpu_wdata | input | PIX_W | CPU write pixel |
| cpu_rdata | output | PIX_W | Registered CPU read pixel |
| buf_addr | output | 2 x (X_W+Y_W) | Address to each frame memory |
| buf_we | output | 2 | Write enable to each frame memory |
| buf_wdata | output | 2 x PIX_W | Write data to each frame memory |
| buf_rdata | input | 2 x PIX_W | Asynchronous read data from each frame memory |
| pix_out | output | PIX_W | Registered colour pixel {R,G,B} |
| front_id | output | 1 | Index of the buffer now on display |
| swap_pending | output | 1 | A swap request is waiting for the frame boundary |

## Verification
If the role flip-flop toggles at the wrong time, two things show at the ports in the same cycle: the display address appears on the other memory's address port, and the write enable moves to the buffer being shown. On the next clock, pix_out starts to show the other buffer's data. If the swap is held wrongly, swap_pending stays high after a boundary or never rises after a request. In both cases front_id then fails to change on the boundary clock, or changes on a clock with only one reset strobe. An upper-latch or read-capture fault shows as a wrong upper address on the back buffer port, or a wrong cpu_rdata, one clock after the load or read.

// File: rtl/pixbuf_pkg.sv
package pixbuf_pkg;

    // Which of the two frame memories is on display.
    typedef enum logic {
        BUF_ZERO = 1'b0,
        BUF_ONE  = 1'b1
    } buf_id_t;

    localparam int NBUF = 2;

endpackage

// File: rtl/pixbuf_swap_ctrl.sv
module pixbuf_swap_ctrl
    import pixbuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    swap_req,
    input  logic    x_reset,
    input  logic    y_reset,
    output buf_id_t front_id,
    output logic    swap_pending
);

    typedef struct packed {
        buf_id_t front;
        logic    pending;
    } swap_state_t;

    swap_state_t st_d, st_q;
    logic        boundary;

    always_comb begin
        st_d     = st_q;
        boundary = x_reset & y_reset;
        if (st_q.pending && boundary) begin
            // Exchange roles; a request in this clock merges into this swap.
            st_d.front   = (st_q.front == BUF_ZERO) ? BUF_ONE : BUF_ZERO;
            st_d.pending = 1'b0;
        end else if (swap_req) begin
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{front: BUF_ZERO, pending: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign front_id     = st_q.front;
    assign swap_pending = st_q.pending;

    AST_SWAP_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (front_id != $past(front_id)) |-> ($past(swap_pending) && $past(x_reset) && $past(y_reset))); // R7

    AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_pending && x_reset && y_reset) |=> !swap_pending); // R7

    AST_REQUEST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req && !swap_pending) |=> swap_pending); // R6

    AST_NO_EARLY_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_pending && !(x_reset && y_reset)) |=> (swap_pending && $stable(front_id))); // R8

endmodule

// File: rtl/pixbuf_cpu_port.sv
module pixbuf_cpu_port #(
    parameter int AW    = 19,
    parameter int HI_W  = 8,
    parameter int PIX_W = 6,
    localparam int LO_W = AW - HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_load,
    input  logic [HI_W-1:0]  hi_data,
    input  logic [LO_W-1:0]  lo_addr,
    input  logic             cpu_rd,
    input  logic [PIX_W-1:0] back_rdata,
    output logic [AW-1:0]    cpu_addr,
    output logic [PIX_W-1:0] cpu_rdata
);

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [PIX_W-1:0] rdata;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hi_load) begin
            st_d.hi = hi_data;
        end
        if (cpu_rd) begin
            st_d.rdata = back_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_addr  = {st_q.hi, lo_addr};
    assign cpu_rdata = st_q.rdata;

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_load |=> (cpu_addr[AW-1:LO_W] == $past(cpu_addr[AW-1:LO_W]))); // R3

    AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        hi_load |=> (cpu_addr[AW-1:LO_W] == $past(hi_data))); // R3

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(cpu_rdata)); // R9

endmodule

// File: rtl/pixbuf_router.sv
module pixbuf_router
    import pixbuf_pkg::*;
#(
    parameter int AW    = 19,
    parameter int PIX_W = 6
) (
    input  buf_id_t                     front_id,
    input  logic [AW-1:0]               disp_addr,
    input  logic [AW-1:0]               cpu_addr,
    input  logic                        cpu_wr,
    input  logic [PIX_W-1:0]            cpu_wdata,
    input  logic [NBUF-1:0][PIX_W-1:0]  buf_rdata,
    output logic [NBUF-1:0][AW-1:0]     buf_addr,
    output logic [NBUF-1:0]             buf_we,
    output logic [NBUF-1:0][PIX_W-1:0]  buf_wdata,
    output logic [PIX_W-1:0]            front_rdata,
    output logic [PIX_W-1:0]            back_rdata
);

    logic front_idx;
    assign front_idx = front_id;

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        localparam logic MY_ID = (i == 1);
        logic is_front;
        assign is_front     = (front_idx == MY_ID);
        assign buf_addr[i]  = is_front ? disp_addr : cpu_addr;
        assign buf_we[i]    = !is_front && cpu_wr;
        assign buf_wdata[i] = cpu_wdata;
    end

    assign front_rdata = buf_rdata[front_idx];
    assign back_rdata  = buf_rdata[!front_idx];

endmodule

// File: rtl/pixbuf_out_reg.sv
module pixbuf_out_reg #(
    parameter int PIX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank,
    input  logic [PIX_W-1:0] front_rdata,
    output logic [PIX_W-1:0] pix_out
);

    typedef struct packed {
        logic [PIX_W-1:0] pix;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d.pix = front_rdata;
        if (blank) begin
            st_d.pix = '0;  // synchronous clear
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_out = st_q.pix;

    AST_BLANK_IS_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (pix_out == '0)); // R5

    AST_PIXEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |=> (pix_out == $past(front_rdata))); // R4

endmodule

// File: rtl/pixbuf_path.sv
module pixbuf_path
    import pixbuf_pkg::*;
#(
    parameter int X_W   = 10,
    parameter int Y_W   = 9,
    parameter int PIX_W = 6,
    parameter int HI_W  = 8,
    localparam int AW   = X_W + Y_W,
    localparam int LO_W = AW - HI_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [AW-1:0]               disp_addr,
    input  logic                        x_reset,
    input  logic                        y_reset,
    input  logic                        blank,
    input  logic                        swap_req,
    input  logic                        cpu_hi_load,
    input  logic [HI_W-1:0]             cpu_hi_data,
    input  logic [LO_W-1:0]             cpu_lo_addr,
    input  logic                        cpu_wr,
    input  logic                        cpu_rd,
    input  logic [PIX_W-1:0]            cpu_wdata,
    output logic [PIX_W-1:0]            cpu_rdata,
    output logic [NBUF-1:0][AW-1:0]     buf_addr,
    output logic [NBUF-1:0]             buf_we,
    output logic [NBUF-1:0][PIX_W-1:0]  buf_wdata,
    input  logic [NBUF-1:0][PIX_W-1:0]  buf_rdata,
    output logic [PIX_W-1:0]            pix_out,
    output logic                        front_id,
    output logic                        swap_pending
);

    buf_id_t          front_w;
    logic [AW-1:0]    cpu_addr_w;
    logic [PIX_W-1:0] front_rdata_w;
    logic [PIX_W-1:0] back_rdata_w;

    pixbuf_swap_ctrl u_swap (
        .clk          (clk),
        .rst_n        (rst_n),
        .swap_req     (swap_req),
        .x_reset      (x_reset),
        .y_reset      (y_reset),
        .front_id     (front_w),
        .swap_pending (swap_pending)
    );

    pixbuf_cpu_port #(.AW(AW), .HI_W(HI_W), .PIX_W(PIX_W)) u_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_load    (cpu_hi_load),
        .hi_data    (cpu_hi_data),
        .lo_addr    (cpu_lo_addr),
        .cpu_rd     (cpu_rd),
        .back_rdata (back_rdata_w),
        .cpu_addr   (cpu_addr_w),
        .cpu_rdata  (cpu_rdata)
    );

    pixbuf_router #(.AW(AW), .PIX_W(PIX_W)) u_route (
        .front_id    (front_w),
        .disp_addr   (disp_addr),
        .cpu_addr    (cpu_addr_w),
        .cpu_wr      (cpu_wr),
        .cpu_wdata   (cpu_wdata),
        .buf_rdata   (buf_rdata),
        .buf_addr    (buf_addr),
        .buf_we      (buf_we),
        .buf_wdata   (buf_wdata),
        .front_rdata (front_rdata_w),
        .back_rdata  (back_rdata_w)
    );

    pixbuf_out_reg #(.PIX_W(PIX_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .blank       (blank),
        .front_rdata (front_rdata_w),
        .pix_out     (pix_out)
    );

    assign front_id = front_w;

    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_we)); // R2

    AST_FRONT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_we[front_id]); // R2

endmodule

// File: tb/pixbuf_path_tb_top.sv
module pixbuf_path_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int X_W   = 4;
    localparam int Y_W   = 3;
    localparam int PIX_W = 6;
    localparam int HI_W  = 3;
    localparam int AW    = X_W + Y_W;
    localparam int LO_W  = AW - HI_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0]   disp_addr = '0;
    logic            x_reset = 1'b0, y_reset = 1'b0, blank = 1'b0, swap_req = 1'b0;
    logic            cpu_hi_load = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [HI_W-1:0] cpu_hi_data = '0;
    logic [LO_W-1:0] cpu_lo_addr = '0;
    logic [PIX_W-1:0] cpu_wdata = '0;
    logic [PIX_W-1:0] cpu_rdata, pix_out;
    logic [1:0][AW-1:0]    buf_addr;
    logic [1:0]            buf_we;
    logic [1:0][PIX_W-1:0] buf_wdata;
    logic [1:0][PIX_W-1:0] buf_rdata;
    logic front_id, swap_pending;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: read data is an arithmetic function of buffer and address.
    function automatic logic [PIX_W-1:0] mdl(int b, int a);
        return PIX_W'((a * 5 + b * 23 + 7) % 64);
    endfunction

    assign buf_rdata[0] = mdl(0, int'(buf_addr[0]));
    assign buf_rdata[1] = mdl(1, int'(buf_addr[1]));

    pixbuf_path #(.X_W(X_W), .Y_W(Y_W), .PIX_W(PIX_W), .HI_W(HI_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .disp_addr(disp_addr), .x_reset(x_reset),
        .y_reset(y_reset), .blank(blank), .swap_req(swap_req),
        .cpu_hi_load(cpu_hi_load), .cpu_hi_data(cpu_hi_data),
        .cpu_lo_addr(cpu_lo_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .buf_addr(buf_addr),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .pix_out(pix_out), .front_id(front_id), .swap_pending(swap_pending)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Display sweep over every address with the given front buffer.
    task automatic disp_sweep(int fr);
        for (int a = 0; a < (1 << AW); a++) begin
            disp_addr = AW'(a);
            blank = (a % 5 == 0);
            #1;
            chk("R2 front addr", int'(buf_addr[fr]), a);
            chk("R2 front we", int'(buf_we[fr]), 0);
            tick();
            if (a % 5 == 0) chk("R5 blank black", int'(pix_out), 0);
            else            chk("R4 pixel", int'(pix_out), int'(mdl(fr, a)));
        end
        blank = 1'b0;
    endtask

    // CPU sweep over every back-buffer address.
    task automatic cpu_sweep(int bk);
        for (int h = 0; h < (1 << HI_W); h++) begin
            cpu_hi_data = HI_W'(h);
            cpu_hi_load = 1'b1;
            tick();
            cpu_hi_load = 1'b0;
            cpu_hi_data = HI_W'(~h);   // must be ignored (R3)
            for (int l = 0; l < (1 << LO_W); l++) begin
                int ad;
                ad = (h << LO_W) | l;
                cpu_lo_addr = LO_W'(l);
                cpu_wdata   = PIX_W'(ad ^ 6'h2b);
                cpu_wr = (l % 2 == 0);
                cpu_rd = (l % 2 == 1);
                #1;
                chk("R3 R2 back addr", int'(buf_addr[bk]), ad);
                chk("R2 back we", int'(buf_we), (l % 2 == 0) ? (1 << bk) : 0);
                chk("R2 back wdata", int'(buf_wdata[bk]), int'(PIX_W'(ad ^ 6'h2b)));
                tick();
                if (l % 2 == 1) chk("R9 read capture", int'(cpu_rdata), int'(mdl(bk, ad)));
            end
            cpu_wr = 1'b0;
            cpu_rd = 1'b0;
            logic_hold_check(bk, h);
        end
    endtask

    task automatic logic_hold_check(int bk, int h);
        logic [PIX_W-1:0] prev;
        prev = cpu_rdata;
        tick();
        chk("R9 rdata hold", int'(cpu_rdata), int'(prev));
        chk("R3 latch hold", int'(buf_addr[bk][AW-1:LO_W]), h);
    endtask

    task automatic strobe(logic xr, logic yr, logic rq);
        x_reset = xr; y_reset = yr; swap_req = rq;
        tick();
        x_reset = 1'b0; y_reset = 1'b0; swap_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pix", int'(pix_out), 0);
        chk("R1 front", int'(front_id), 0);
        chk("R1 pending", int'(swap_pending), 0);
        chk("R1 rdata", int'(cpu_rdata), 0);
        chk("R1 we", int'(buf_we), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        cpu_sweep(1);
        disp_sweep(0);

        // R6: request held, no change until a full boundary
        strobe(1'b0, 1'b0, 1'b1);
        chk("R6 pending set", int'(swap_pending), 1);
        chk("R6 front held", int'(front_id), 0);
        strobe(1'b1, 1'b0, 1'b0);
        chk("R7 x only", int'(front_id), 0);
        chk("R7 x only pend", int'(swap_pending), 1);
        strobe(1'b0, 1'b1, 1'b1);
        chk("R7 y only", int'(front_id), 0);
        chk("R8 merge pend", int'(swap_pending), 1);
        strobe(1'b1, 1'b1, 1'b0);
        chk("R7 swapped", int'(front_id), 1);
        chk("R7 pend clear", int'(swap_pending), 0);
        strobe(1'b1, 1'b1, 1'b0);
        chk("R7 no pend no swap", int'(front_id), 1);

        disp_sweep(1);
        cpu_sweep(0);

        // R8: request on boundary with nothing pending only sets pending
        strobe(1'b1, 1'b1, 1'b1);
        chk("R8 boundary req front", int'(front_id), 1);
        chk("R8 boundary req pend", int'(swap_pending), 1);
        // R8: request during the swapping boundary merges
        strobe(1'b1, 1'b1, 1'b1);
        chk("R8 merged swap front", int'(front_id), 0);
        chk("R8 merged swap pend", int'(swap_pending), 0);
        strobe(1'b1, 1'b1, 1'b0);
        chk("R8 single swap only", int'(front_id), 0);

        disp_sweep(0);

        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

endmodule